// File: doc/BRIEF.md
# Endian-Aware Byte-Lane Aligner

This block sits between a processor's load/store unit and a 64-bit memory data path. For a load it receives the physical address, a length code and the raw value fetched from memory, right-aligned. It then moves the referenced bytes into the register byte lanes that the selected memory endianness calls for. For a store it does the reverse. It pulls the referenced bytes out of their lanes into a right-aligned value for memory and produces a byte-enable mask that marks the lanes of the 8-byte element being written.

Accesses from one to eight bytes are supported, including the non-power-of-two sizes of three, five, six and seven bytes. A quadword code passes two 64-bit halves through unshifted. The block flags any access that would spill past its aligned element, and any length code it does not define. Results appear on registered outputs one clock after the request.

Top module: `bytelane_align`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock, and every output is zero during reset.
- R2: For a length code L of 0 to 7 (access size L+1 bytes) with element offset O = `in_addr[2:0]`, the access is a boundary error when O + L > 7. `out_err` is then high for that result.
- R3: Length codes 8 to 14 are undefined and always give `out_err` high.
- R4: Code 15 is a quadword. If `in_addr[3:0]` is 0, `out_lo`/`out_hi` carry `in_lo`/`in_hi` unchanged and a store sets `out_be` to 8'hFF. Otherwise it is an error. For every non-quadword result, `out_hi` is 0.
- R5: Little-endian load (`in_big`=0, `in_store`=0): `out_lo` is the low L+1 bytes of `in_lo` shifted left by O×8 bits.
- R6: Big-endian load (`in_big`=1): the low L+1 bytes of `in_lo` are shifted left by (7−O−L)×8 bits.
- R7: On a load, bytes of `in_lo` above the low L+1 bytes do not reach `out_lo`.
- R8: Store (`in_store`=1): `out_lo` is `in_lo` shifted right by the same amount as the matching load (O×8 little-endian, (7−O−L)×8 big-endian), keeping only its low L+1 bytes.
- R9: A store's `out_be` has L+1 contiguous set bits, starting at bit O for little-endian or at bit 7−O−L for big-endian. Bit i of `out_be` marks data bits 8i+7..8i.
- R10: When `out_err` is high, `out_lo`, `out_hi` and `out_be` are all zero. `out_err` never rises without `out_valid`.
- R11: A load never sets any bit of `out_be`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_store | input | 1 | 1 = store, 0 = load |
| in_big | input | 1 | 1 = big-endian memory, 0 = little-endian |
| in_addr | input | 32 | Physical byte address |
| in_len | input | 4 | Length code: byte count minus one, 15 = quadword |
| in_lo | input | 64 | Load: fetched value. Store: register value. Low half for quadword |
| in_hi | input | 64 | High half for quadword, ignored otherwise |
| out_valid | output | 1 | Result present |
| out_err | output | 1 | Boundary or length error for this result |
| out_lo | output | 64 | Aligned data, low half |
| out_hi | output | 64 | High half of quadword data |
| out_be | output | 8 | Store byte enables per lane |

## Verification
The bound checker watches several properties on every clock. It checks the one-cycle valid latency and that an error never appears without a valid result. It also checks that an error always comes with empty byte enables, that a narrow store enables exactly as many lanes as the length code asks for, and that the high half stays zero outside quadword mode. What the properties cannot see is where each byte lands for a given offset and endianness. The bench shows this through a table of loads and stores of every size in both byte orders, with a byte-wise model. Directed cases cover ignored upper bytes, the quadword path, undefined length codes and zeroed data on errors.

// File: rtl/bla_pkg.sv
package bla_pkg;
   // Width of the access-length code; the all-ones value selects quadword.
   localparam int unsigned LEN_W    = 4;
   localparam logic [LEN_W-1:0] LEN_QUAD = '1;

   typedef enum logic {
      XFER_LOAD  = 1'b0,
      XFER_STORE = 1'b1
   } xfer_e;
endpackage

// File: rtl/bla_decode.sv
module bla_decode
   import bla_pkg::*;
#(
   parameter int unsigned LANES   = 8,
   parameter int unsigned ADDR_W  = 32,
   parameter bit          QUAD_EN = 1'b1,
   localparam int unsigned OFF_W  = $clog2(LANES)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   input  logic              big,
   output logic [OFF_W-1:0]  sh_bytes,
   output logic [LANES-1:0]  len_mask,
   output logic              quad,
   output logic              bad
);
   localparam int unsigned SUM_W = LEN_W + 1;

   logic [OFF_W-1:0] off;
   logic [SUM_W-1:0] span_end;
   logic [SUM_W-1:0] rev_sh;
   logic             narrow;
   logic             spill;
   logic             quad_mis;

   assign off      = addr[OFF_W-1:0];
   assign span_end = SUM_W'(off) + SUM_W'(len);
   assign rev_sh   = SUM_W'(LANES - 1) - span_end;
   assign narrow   = (len < LEN_W'(LANES));
   assign spill    = narrow && (span_end > SUM_W'(LANES - 1));

   generate
      if (QUAD_EN) begin : g_quad
         assign quad     = (len == LEN_QUAD);
         assign quad_mis = (addr[OFF_W:0] != '0);
      end else begin : g_noquad
         assign quad     = 1'b0;
         assign quad_mis = 1'b0;
      end
   endgenerate

   assign bad      = quad ? quad_mis : (!narrow || spill);
   assign sh_bytes = big ? rev_sh[OFF_W-1:0] : off;

   // One bit per byte covered by the access, right-aligned.
   generate
      for (genvar i = 0; i < LANES; i++) begin : g_mask
         assign len_mask[i] = (LEN_W'(i) <= len);
      end
   endgenerate
endmodule

// File: rtl/bla_shift.sv
module bla_shift #(
   parameter int unsigned LANES = 8,
   parameter bit          LEFT  = 1'b1,
   localparam int unsigned OFF_W = $clog2(LANES),
   localparam int unsigned W     = LANES * 8
) (
   input  logic [W-1:0]     d,
   input  logic [OFF_W-1:0] sh_bytes,
   output logic [W-1:0]     q
);
   logic [OFF_W+2:0] sh_bits;
   assign sh_bits = {sh_bytes, 3'b000};

   generate
      if (LEFT) begin : g_left
         assign q = d << sh_bits;
      end else begin : g_right
         assign q = d >> sh_bits;
      end
   endgenerate
endmodule

// File: rtl/bla_expand.sv
module bla_expand #(
   parameter int unsigned LANES = 8
) (
   input  logic [LANES-1:0]   lane_mask,
   output logic [LANES*8-1:0] bit_mask
);
   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign bit_mask[i*8 +: 8] = {8{lane_mask[i]}};
      end
   endgenerate
endmodule

// File: rtl/bytelane_align.sv
module bytelane_align
   import bla_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned DATA_W  = 64,
   parameter bit          QUAD_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic                   in_store,
   input  logic                   in_big,
   input  logic [ADDR_W-1:0]      in_addr,
   input  logic [LEN_W-1:0]       in_len,
   input  logic [DATA_W-1:0]      in_lo,
   input  logic [DATA_W-1:0]      in_hi,
   output logic                   out_valid,
   output logic                   out_err,
   output logic [DATA_W-1:0]      out_lo,
   output logic [DATA_W-1:0]      out_hi,
   output logic [DATA_W/8-1:0]    out_be
);
   localparam int unsigned LANES = DATA_W / 8;
   localparam int unsigned OFF_W = $clog2(LANES);

   generate
      if (DATA_W % 8 != 0) begin : g_chk_w
         $error("DATA_W must be a whole number of bytes");
      end
      if (LANES < 2 || LANES > 8 || (1 << OFF_W) != LANES) begin : g_chk_l
         $error("lane count must be a power of two from 2 to 8");
      end
      if (ADDR_W <= OFF_W + 1) begin : g_chk_a
         $error("ADDR_W too narrow for element offset");
      end
   endgenerate

   logic [OFF_W-1:0]  sh_bytes;
   logic [LANES-1:0]  len_mask;
   logic              is_quad;
   logic              is_bad;
   logic [DATA_W-1:0] byte_mask;
   logic [DATA_W-1:0] ld_src;
   logic [DATA_W-1:0] ld_pos;
   logic [DATA_W-1:0] st_pos;
   logic [LANES-1:0]  st_be;
   xfer_e             kind;

   logic [DATA_W-1:0] nxt_lo;
   logic [DATA_W-1:0] nxt_hi;
   logic [LANES-1:0]  nxt_be;

   bla_decode #(
      .LANES   (LANES),
      .ADDR_W  (ADDR_W),
      .QUAD_EN (QUAD_EN)
   ) u_dec (
      .addr     (in_addr),
      .len      (in_len),
      .big      (in_big),
      .sh_bytes (sh_bytes),
      .len_mask (len_mask),
      .quad     (is_quad),
      .bad      (is_bad)
   );

   bla_expand #(.LANES(LANES)) u_exp (
      .lane_mask (len_mask),
      .bit_mask  (byte_mask)
   );

   // Load path: trim the fetched value to its length, then move it up.
   assign ld_src = in_lo & byte_mask;

   bla_shift #(.LANES(LANES), .LEFT(1'b1)) u_ld_sh (
      .d        (ld_src),
      .sh_bytes (sh_bytes),
      .q        (ld_pos)
   );

   // Store path: move the register value down, trim after the shift.
   bla_shift #(.LANES(LANES), .LEFT(1'b0)) u_st_sh (
      .d        (in_lo),
      .sh_bytes (sh_bytes),
      .q        (st_pos)
   );

   assign st_be = len_mask << sh_bytes;
   assign kind  = in_store ? XFER_STORE : XFER_LOAD;

   always_comb begin
      nxt_lo = '0;
      nxt_hi = '0;
      nxt_be = '0;
      if (!is_bad) begin
         if (is_quad) begin
            nxt_lo = in_lo;
            nxt_hi = in_hi;
            if (kind == XFER_STORE) nxt_be = '1;
         end else if (kind == XFER_STORE) begin
            nxt_lo = st_pos & byte_mask;
            nxt_be = st_be;
         end else begin
            nxt_lo = ld_pos;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_err   <= 1'b0;
         out_lo    <= '0;
         out_hi    <= '0;
         out_be    <= '0;
      end else begin
         out_valid <= in_valid;
         out_err   <= in_valid && is_bad;
         if (in_valid) begin
            out_lo <= nxt_lo;
            out_hi <= nxt_hi;
            out_be <= nxt_be;
         end
      end
   end
endmodule

// File: rtl/bla_check.sv
module bla_check #(
   parameter int unsigned DATA_W = 64
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic [3:0]          in_len,
   input logic                out_valid,
   input logic                out_err,
   input logic [DATA_W-1:0]   out_hi,
   input logic [DATA_W/8-1:0] out_be
);
   a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   a_r10_err_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> out_valid);

   a_r10_err_no_be: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> (out_be == '0));

   a_r9_be_count: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_err && out_be != '0 && $past(in_len) != 4'hF)
      |-> ($countones(out_be) == int'($past(in_len)) + 1));

   a_r4_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_len) != 4'hF) |-> (out_hi == '0));
endmodule

bind bytelane_align bla_check #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_len    (in_len),
   .out_valid (out_valid),
   .out_err   (out_err),
   .out_hi    (out_hi),
   .out_be    (out_be)
);

// File: tb/sim_bytelane_align.sv
module sim_bytelane_align;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_store = 1'b0;
   logic        in_big = 1'b0;
   logic [31:0] in_addr = '0;
   logic [3:0]  in_len = '0;
   logic [63:0] in_lo = '0;
   logic [63:0] in_hi = '0;
   logic        out_valid;
   logic        out_err;
   logic [63:0] out_lo;
   logic [63:0] out_hi;
   logic [7:0]  out_be;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   bytelane_align u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_store(in_store),
      .in_big(in_big), .in_addr(in_addr), .in_len(in_len), .in_lo(in_lo),
      .in_hi(in_hi), .out_valid(out_valid), .out_err(out_err),
      .out_lo(out_lo), .out_hi(out_hi), .out_be(out_be)
   );

   // {store, big, offset[2:0], len[3:0], data[63:0], expected error}
   localparam int NV = 14;
   localparam logic [73:0] VEC [NV] = '{
      {1'b0, 1'b0, 3'd0, 4'd7, 64'h0123_4567_89AB_CDEF, 1'b0},
      {1'b0, 1'b0, 3'd2, 4'd1, 64'h0000_0000_0000_BEEF, 1'b0},
      {1'b0, 1'b1, 3'd2, 4'd1, 64'h0000_0000_0000_BEEF, 1'b0},
      {1'b0, 1'b0, 3'd1, 4'd2, 64'h0000_0000_00A1_B2C3, 1'b0},
      {1'b0, 1'b1, 3'd1, 4'd4, 64'h0000_0011_2233_4455, 1'b0},
      {1'b0, 1'b1, 3'd0, 4'd5, 64'h0000_6655_4433_2211, 1'b0},
      {1'b0, 1'b0, 3'd1, 4'd6, 64'h0077_6655_4433_2211, 1'b0},
      {1'b1, 1'b0, 3'd3, 4'd3, 64'h0102_0304_0506_0708, 1'b0},
      {1'b1, 1'b1, 3'd4, 4'd3, 64'hCAFE_F00D_1234_5678, 1'b0},
      {1'b1, 1'b1, 3'd1, 4'd5, 64'h8877_6655_4433_2211, 1'b0},
      {1'b1, 1'b0, 3'd5, 4'd2, 64'hFFEE_DDCC_BBAA_9988, 1'b0},
      {1'b0, 1'b0, 3'd4, 4'd4, 64'h0000_0011_2233_4455, 1'b1},
      {1'b1, 1'b1, 3'd7, 4'd1, 64'h1111_2222_3333_4444, 1'b1},
      {1'b1, 1'b0, 3'd0, 4'd7, 64'hDEAD_BEEF_0BAD_F00D, 1'b0}
   };

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Byte-wise reference: byte k of the access sits in lane base+k.
   function automatic int lane_base(bit big, int off, int len);
      return big ? (7 - off - len) : off;
   endfunction

   function automatic logic [63:0] model_data(bit st, bit big, int off,
                                              int len, logic [63:0] d);
      logic [63:0] r = '0;
      int b = lane_base(big, off, len);
      for (int k = 0; k <= len; k++) begin
         if (st) r[8*k +: 8] = d[8*(b+k) +: 8];
         else    r[8*(b+k) +: 8] = d[8*k +: 8];
      end
      return r;
   endfunction

   function automatic logic [7:0] model_be(bit st, bit big, int off, int len);
      logic [7:0] r = '0;
      int b = lane_base(big, off, len);
      if (st) for (int k = 0; k <= len; k++) r[b+k] = 1'b1;
      return r;
   endfunction

   task automatic issue(input bit st, input bit big, input logic [31:0] a,
                        input logic [3:0] len, input logic [63:0] lo,
                        input logic [63:0] hi);
      @(negedge clk);
      in_valid = 1'b1; in_store = st; in_big = big; in_addr = a;
      in_len = len; in_lo = lo; in_hi = hi;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(out_valid == 0 && out_err == 0, "R1", "reset valid/err",
          {62'd0, out_valid, out_err}, 64'd0);
      chk(out_lo == 0 && out_hi == 0 && out_be == 0, "R1", "reset data",
          out_lo | out_hi | {56'd0, out_be}, 64'd0);
      rst_n = 1'b1;

      // Table walk: R2 R5 R6 R8 R9 R10 R11
      for (int i = 0; i < NV; i++) begin
         bit          st   = VEC[i][73];
         bit          big  = VEC[i][72];
         int          off  = int'(VEC[i][71:69]);
         int          len  = int'(VEC[i][68:65]);
         logic [63:0] d    = VEC[i][64:1];
         bit          xerr = VEC[i][0];
         string       tag;
         tag = xerr ? "R2" : (st ? "R8" : (big ? "R6" : "R5"));
         issue(st, big, 32'h0000_1000 | 32'(off), 4'(len), d, 64'hFFFF_FFFF_FFFF_FFFF);
         chk(out_valid == 1'b1, "R1", "valid after one cycle", {63'd0, out_valid}, 64'd1);
         chk(out_err == xerr, tag, "error flag", {63'd0, out_err}, {63'd0, xerr});
         if (xerr) begin
            chk(out_lo == 0 && out_be == 0, "R10", "zeroed on error",
                out_lo | {56'd0, out_be}, 64'd0);
         end else begin
            chk(out_lo == model_data(st, big, off, len, d), tag, "data",
                out_lo, model_data(st, big, off, len, d));
            chk(out_be == model_be(st, big, off, len), st ? "R9" : "R11", "byte enables",
                {56'd0, out_be}, {56'd0, model_be(st, big, off, len)});
            chk(out_hi == 0, "R4", "high half zero when narrow", out_hi, 64'd0);
         end
      end

      // R1: valid drops one cycle after request ends
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "valid pulse width", {63'd0, out_valid}, 64'd0);

      // R7: upper bytes of fetched value ignored on load
      issue(1'b0, 1'b0, 32'h0000_2000, 4'd1, 64'hFFFF_FFFF_FFFF_1234, '0);
      chk(out_lo == 64'h1234, "R7", "LE load trims upper bytes", out_lo, 64'h1234);
      issue(1'b0, 1'b1, 32'h0000_2004, 4'd0, 64'hABCD_EF01_2345_67C3, '0);
      chk(out_lo == 64'h0000_0000_C300_0000, "R7", "BE byte load trims",
          out_lo, 64'h0000_0000_C300_0000);

      // R4: quadword pass-through
      issue(1'b1, 1'b1, 32'h0000_3010, 4'hF, 64'h1111_2222_3333_4444,
            64'h5555_6666_7777_8888);
      chk(out_err == 0 && out_be == 8'hFF, "R4", "quad store enables",
          {55'd0, out_err, out_be}, 64'h0FF);
      chk(out_lo == 64'h1111_2222_3333_4444 && out_hi == 64'h5555_6666_7777_8888,
          "R4", "quad halves", out_hi, 64'h5555_6666_7777_8888);
      issue(1'b0, 1'b0, 32'h0000_3020, 4'hF, 64'h0A0B, 64'h0C0D);
      chk(out_lo == 64'h0A0B && out_hi == 64'h0C0D && out_be == 0, "R4",
          "quad load", out_lo, 64'h0A0B);
      issue(1'b1, 1'b0, 32'h0000_3008, 4'hF, 64'h1, 64'h2);
      chk(out_err == 1 && out_hi == 0 && out_be == 0, "R4", "quad misaligned",
          {63'd0, out_err}, 64'd1);

      // R3: undefined length codes
      issue(1'b0, 1'b0, 32'h0000_4000, 4'd9, 64'h55, '0);
      chk(out_err == 1 && out_lo == 0, "R3", "code 9 error", {63'd0, out_err}, 64'd1);
      issue(1'b1, 1'b1, 32'h0000_4000, 4'd14, 64'h55, '0);
      chk(out_err == 1 && out_be == 0, "R3", "code 14 error", {63'd0, out_err}, 64'd1);

      // R2: largest legal spans at the element edge
      issue(1'b1, 1'b0, 32'h0000_5007, 4'd0, 64'h0000_0000_0000_AB00, '0);
      chk(out_err == 0 && out_be == 8'h80, "R2", "byte at offset 7",
          {56'd0, out_be}, 64'h80);
      issue(1'b1, 1'b0, 32'h0000_5001, 4'd7, 64'h0, '0);
      chk(out_err == 1, "R2", "doubleword at offset 1", {63'd0, out_err}, 64'd1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule